// File: doc/BRIEF.md
# Self-Timed Successive-Approximation Sequencer with Pause Window

This block sequences one successive-approximation conversion of `NBITS` (default 7) bits. It runs on a fast clock and stands in for a self-timed loop. When the sampling phase ends it raises a comparison request. Each comparator completion then captures one decision and launches the next request, so no conversion clock paces the bits. The bits are resolved most significant first. The upper `NBITS-1` bits of the working trial word drive an external capacitor DAC. The last bit is resolved by the comparator alone.

A pause trigger with a 2-bit duration code opens a hold-off window. While the window is open no new comparison request can be issued, which keeps the reference quiet while a neighbouring flash array samples it. A comparison that is already running is neither cut short nor altered by the window. When the final decision arrives, the block latches the complete code and pulses a done flag. The code stays on the output until the next sampling phase starts. The result output has no back-pressure: the consumer must take it while it is held, and the request/valid pair to the comparator is the block's only handshake.

Top module: `sar_async_seq`

## Requirements
- R1: After reset, `cmp_req_o`, `done_o`, `dac_code_o` and `result_o` are all zero.
- R2: The first rising clock edge that samples `sample_i` low after it was high moves the sequencer to a pending state. `cmp_req_o` rises at the following edge, and at that point `dac_code_o` is `100000` (only its top bit set).
- R3: `cmp_req_o` stays high until an edge samples `cmp_valid_i` high, and it falls at that edge.
- R4: With no pause window open, the next request rises exactly one edge after the edge that consumed the valid, so the request is low for one cycle between comparisons.
- R5: Decisions are taken MSB first. `cmp_decision_i` = 1 keeps the bit on trial and 0 clears it, and the next lower bit is then set as the new trial bit. `dac_code_o` is trial bits [NBITS-1:1]. With an ideal comparator (decision = input >= trial word) the result equals the input.
- R6: Exactly NBITS comparisons form one conversion. After the last one, no request is raised until a new sampling phase ends.
- R7: `done_o` is high for exactly one cycle, set by the edge that consumes the final valid. `result_o` takes the final code at that same edge, and `cmp_req_o` is never high together with `done_o`.
- R8: `result_o` holds its value until an edge first samples `sample_i` high, and that edge clears it to zero.
- R9: When an edge samples a rising `pause_i` with `pause_len_i` = c (0..3), no request can rise at that edge or at the next c edges. A pause that starts during a pending gap therefore stretches the gap from 1 cycle to c+2 cycles.
- R10: A pause window that opens while a request is high leaves that request high. It does not change the decision captured for that bit, and it delays only a later request.
- R11: A rise of `sample_i` during a conversion aborts it: the request is low after that edge and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sample_i | input | 1 | high while the input is sampled; its fall starts a conversion |
| cmp_valid_i | input | 1 | comparator completion pulse |
| cmp_decision_i | input | 1 | comparator decision, 1 = input at or above trial |
| pause_i | input | 1 | pause trigger, rising edge opens the hold-off window |
| pause_len_i | input | 2 | hold-off length code, c gives c+1 blocked edges |
| cmp_req_o | output | 1 | comparison request |
| dac_code_o | output | 6 | upper trial bits driving the capacitor DAC |
| result_o | output | 7 | completed conversion code |
| done_o | output | 1 | one-cycle completion pulse |

## Verification
The case that needs care is a pause window arriving in the same cycle as the capture-and-relaunch path. The bench fires the pause trigger on the cycle right after a decision is consumed, while the next request is pending, and checks that the one-cycle gap grows to exactly c+2 cycles for every code. It also raises the trigger on the cycle a request first appears. That request must stay up, the decision it captures must still lead to the exact input value, and the following gap must stay at one cycle because a four-cycle comparator latency outlasts the window.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no conversion running
    ST_WAIT = 2'd1,  // next request pending, waiting out any pause window
    ST_REQ  = 2'd2   // comparison requested, waiting for valid
  } seq_st_e;
endpackage

// File: rtl/sar_pause_timer.sv
module sar_pause_timer #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pause_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             hold_o
);
  logic             pause_q;
  logic [LEN_W-1:0] cnt_q;
  logic             trig;

  assign trig   = pause_i & ~pause_q;
  // the trigger edge itself plus len_i more edges are blocked
  assign hold_o = trig | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pause_q <= pause_i;
      if (trig)
        cnt_q <= len_i;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == $past(len_i)));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cap_i,
  input  logic             dec_i,
  output logic [NBITS-2:0] dac_o,
  output logic [NBITS-1:0] nxt_o,
  output logic             last_o
);
  localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] trial_q;
  logic [NBITS-1:0] ptr_q;
  logic [NBITS-1:0] nxt;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (i == NBITS-1) begin : g_top
      assign nxt[i] = ptr_q[i] ? dec_i : trial_q[i];
    end else begin : g_low
      assign nxt[i] = ptr_q[i] ? dec_i : (ptr_q[i+1] ? 1'b1 : trial_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
    end else if (load_i) begin
      trial_q <= TOP;
      ptr_q   <= TOP;
    end else if (cap_i) begin
      trial_q <= nxt;
      ptr_q   <= ptr_q >> 1;
    end
  end

  assign dac_o  = trial_q[NBITS-1:1];
  assign nxt_o  = nxt;
  assign last_o = ptr_q[0];

  // R5
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));
  // R5
  walk_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !load_i && !ptr_q[0]) |=> $countones(ptr_q) == 1);
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic valid_i,
  input  logic hold_i,
  input  logic last_i,
  output logic load_o,
  output logic cap_o,
  output logic clr_o,
  output logic fin_o,
  output logic req_o,
  output logic done_o
);
  seq_st_e st_q, st_d;
  logic    sample_q;
  logic    fall, rise;
  logic    done_q;

  assign fall = sample_q & ~sample_i;
  assign rise = sample_i & ~sample_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    cap_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (fall) begin
        load_o = 1'b1;
        st_d   = ST_WAIT;
      end
      ST_WAIT: if (!hold_i) st_d = ST_REQ;
      ST_REQ:  if (valid_i) begin
        cap_o = 1'b1;
        st_d  = last_i ? ST_IDLE : ST_WAIT;
      end
      default: st_d = ST_IDLE;
    endcase
    if (rise) begin
      st_d   = ST_IDLE;
      load_o = 1'b0;
      cap_o  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sample_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      sample_q <= sample_i;
      done_q   <= cap_o & last_i;
    end
  end

  assign clr_o  = rise;
  assign fin_o  = cap_o & last_i;
  assign req_o  = (st_q == ST_REQ);
  assign done_o = done_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !valid_i && !sample_i) |=> req_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_o);
endmodule

// File: rtl/sar_async_seq.sv
module sar_async_seq #(
  parameter int NBITS = 7,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             cmp_valid_i,
  input  logic             cmp_decision_i,
  input  logic             pause_i,
  input  logic [LEN_W-1:0] pause_len_i,
  output logic             cmp_req_o,
  output logic [NBITS-2:0] dac_code_o,
  output logic [NBITS-1:0] result_o,
  output logic             done_o
);
  logic             hold, last, load, cap, clr, fin;
  logic [NBITS-1:0] nxt;
  logic [NBITS-1:0] result_q;

  sar_pause_timer #(.LEN_W(LEN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .pause_i(pause_i),
    .len_i  (pause_len_i),
    .hold_o (hold)
  );

  sar_trial_reg #(.NBITS(NBITS)) u_trial (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .cap_i (cap),
    .dec_i (cmp_decision_i),
    .dac_o (dac_code_o),
    .nxt_o (nxt),
    .last_o(last)
  );

  sar_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample_i(sample_i),
    .valid_i (cmp_valid_i),
    .hold_i  (hold),
    .last_i  (last),
    .load_o  (load),
    .cap_o   (cap),
    .clr_o   (clr),
    .fin_o   (fin),
    .req_o   (cmp_req_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   result_q <= '0;
    else if (clr) result_q <= '0;
    else if (fin) result_q <= nxt;
  end
  assign result_o = result_q;

  // R9
  pause_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cmp_req_o) |=> !cmp_req_o);
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !$past(sample_i)) |=> (!cmp_req_o && !done_o));
  // R8
  result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && !done_o && !$past(done_o)) |=> $stable(result_o) || done_o);
endmodule

// File: tb/sar_async_seq_bench.sv
module sar_async_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_i = 1'b0;
  logic       cmp_valid_i = 1'b0;
  logic       cmp_decision_i = 1'b0;
  logic       pause_i = 1'b0;
  logic [1:0] pause_len_i = 2'd0;
  logic       cmp_req_o;
  logic [5:0] dac_code_o;
  logic [6:0] result_o;
  logic       done_o;

  sar_async_seq u_sar_async_seq (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
    .cmp_valid_i(cmp_valid_i), .cmp_decision_i(cmp_decision_i),
    .pause_i(pause_i), .pause_len_i(pause_len_i),
    .cmp_req_o(cmp_req_o), .dac_code_o(dac_code_o),
    .result_o(result_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  int vin_cur = 0, pz_mode = 0, pz_bit = 0, lat = 0;
  int bidx = 0, wcnt = 0, gap_cnt = 0, gap_exp = 1, dones = 0;
  bit in_gap = 0, done_prev = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // responder: ideal comparator plus pause injection
  always @(negedge clk) begin
    if (!rst_n || sample_i) begin
      bidx = 0; wcnt = 0; in_gap = 0; cmp_valid_i = 0; pause_i = 0;
    end else begin
      pause_i = 0;
      if (cmp_valid_i) begin
        cmp_valid_i = 0;
        // R3: request dropped at the consuming edge
        chk(cmp_req_o == 0, "R3 req falls with valid", cmp_req_o, 0);
        if (bidx < 7) begin
          in_gap = 1; gap_cnt = 0;
          if (pz_mode == 1 && bidx - 1 == pz_bit) begin
            pause_i = 1; gap_exp = pause_len_i + 2;
          end else gap_exp = 1;
        end
      end
      if (cmp_req_o) begin
        if (in_gap) begin
          // R4 / R9: width of the gap between requests
          chk(gap_cnt == gap_exp, (gap_exp == 1) ? "R4 gap" : "R9 pause gap", gap_cnt, gap_exp);
          in_gap = 0;
        end
        if (wcnt == 0) begin
          int pos, et;
          pos = 6 - bidx;
          et = (vin_cur & ~((1 << (pos + 1)) - 1)) | (1 << pos);
          // R5: upper six trial bits on the DAC
          chk(dac_code_o == et[6:1], "R5 dac trial", dac_code_o, et[6:1]);
          if (pz_mode == 2 && bidx == pz_bit) pause_i = 1;
        end
        if (wcnt >= lat) begin
          int pos, et;
          pos = 6 - bidx;
          et = (vin_cur & ~((1 << (pos + 1)) - 1)) | (1 << pos);
          cmp_decision_i = (vin_cur >= et);
          cmp_valid_i = 1;
          bidx++; wcnt = 0;
        end else wcnt++;
      end else begin
        if (in_gap) gap_cnt++;
        // R10: request may not drop while waiting for valid
        if (wcnt > 0) begin
          chk(0, "R10 request dropped", 0, 1); wcnt = 0;
        end
      end
    end
  end

  // monitor: scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev)
        chk(done_o == 0, "R7 done width", done_o, 0);
      if (done_o) begin
        dones++;
        if (exp_q.size() == 0) chk(0, "R11 done without conversion", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(result_o == e, "R5 result", result_o, e);
          chk(bidx == 7, "R6 comparison count", bidx, 7);
          chk(cmp_req_o == 0, "R7 req with done", cmp_req_o, 0);
        end
      end
      done_prev = done_o;
    end
  end

  task automatic start_sample(input int vin, input bit chk_clr);
    @(negedge clk);
    vin_cur = vin;
    sample_i = 1;
    @(negedge clk);
    if (chk_clr) chk(result_o == 0, "R8 cleared on sampling", result_o, 0);
    @(negedge clk);
    sample_i = 0;
    @(negedge clk);
    chk(cmp_req_o == 0, "R2 pending after fall", cmp_req_o, 0);
    @(negedge clk);
    chk(cmp_req_o == 1, "R2 first request", cmp_req_o, 1);
  endtask

  task automatic convert(input int vin, input int mode, input int pbit,
                         input int code, input int l);
    int d0;
    pz_mode = mode; pz_bit = pbit; pause_len_i = code[1:0]; lat = l;
    d0 = dones;
    exp_q.push_back(vin);
    start_sample(vin, 1);
    while (dones == d0) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk(result_o == vin, "R8 result held", result_o, vin);
      chk(cmp_req_o == 0, "R6 no extra request", cmp_req_o, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cmp_req_o == 0, "R1 req", cmp_req_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(result_o == 0, "R1 result", result_o, 0);
    chk(dac_code_o == 0, "R1 dac", dac_code_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    convert(85, 0, 0, 0, 0);
    convert(127, 0, 0, 0, 2);
    convert(0, 0, 0, 0, 1);
    convert(42, 1, 1, 0, 0);   // R9 code 0
    convert(100, 1, 3, 1, 1);  // R9 code 1
    convert(63, 1, 0, 2, 0);   // R9 code 2
    convert(64, 1, 5, 3, 2);   // R9 code 3
    convert(91, 2, 2, 3, 4);   // R10 pause during a comparison
    convert(1, 2, 6, 2, 4);    // R10 on the final bit

    // R11: abort mid-conversion
    pz_mode = 0; lat = 1;
    start_sample(77, 1);
    while (bidx < 3) @(negedge clk);
    sample_i = 1;
    @(negedge clk);
    chk(cmp_req_o == 0, "R11 req after abort", cmp_req_o, 0);
    chk(result_o == 0, "R11 result after abort", result_o, 0);
    sample_i = 0;
    repeat (6) begin
      @(negedge clk);
      chk(done_o == 0, "R11 no done", done_o, 0);
    end
    convert(19, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule